// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register front end of an I/O interrupt controller. A bus master reaches every internal register through two locations: a select register holding an 8-bit index, and a 32-bit data window that reads or writes whichever register the index names. The registers behind the window are a controller ID, a read-only version word and a table of 64-bit redirection entries, one for each interrupt pin. Each entry is reached as two 32-bit halves.

On a window write, the block merges the new half into the entry. It keeps the hardware-owned status bits (remote IRR and delivery status) as they were. The delivery logic updates those bits through a dedicated status port. When an entry ends up edge-triggered, its remote IRR bit is cleared. When its mask bit changes, a one-cycle notification carries the pin number and the new mask value. A write that leaves an entry level-triggered while the pin's request bit is set raises a one-cycle service request for that pin. Interrupt delivery and end-of-interrupt handling are left to neighbouring logic.

Top module: `irq_window_top`

## Requirements
- R1: A bus write to offset 0x00 stores the low 8 bits of the data into the select register. A read of offset 0x00 returns the stored select value zero-extended.
- R2: Only offsets 0x00 (select) and 0x10 (window) are decoded. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R3: With select 0x01 the window reads the version word: pins−1 (0x17 for 24 pins) in bits 23:16 and version code 0x11 in bits 7:0, all other bits 0. Window writes at select 0x01 are ignored.
- R4: With select 0x00 or 0x02 the window reads the 4-bit controller ID in bits 27:24 and 0 elsewhere. A window write at select 0x00 stores data bits 27:24 as the ID. A window write at select 0x02 is ignored.
- R5: A select S ≥ 0x10 addresses entry (S−0x10)>>1. An odd S reaches entry bits 63:32 and an even S reaches bits 31:0. A write to one half leaves the other half and all other entries unchanged.
- R6: A window read at a select that names no register (0x03–0x0F, or an entry number ≥ the pin count) returns 0xFFFFFFFF. A write there is discarded.
- R7: Entry bit 12 (delivery status) and bit 14 (remote IRR) keep their previous values on a window write. They change only through the status port, which loads both bits of the named pin.
- R8: If an entry's trigger bit 15 is 0 (edge) after a window write, its remote IRR bit 14 becomes 0.
- R9: A window write that changes an entry's mask bit 16 produces maskChgValid for exactly the next cycle, with maskChgPin the entry number and maskChgValue the new mask. A write that keeps the mask produces no pulse.
- R10: A window write after which the entry's trigger bit 15 is 1 (level) while pinPending of that pin is 1 produces svcReqValid for the next cycle, with svcReqPin the entry number. No service request is raised otherwise.
- R11: Reset clears the select register, the ID and every entry except bit 16 (mask), which is set. Each entry's low half then reads 0x00010000.
- R12: Read data and busRdValid appear in the cycle after the clock edge that accepts the read. busRdValid is 0 in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset within the register region |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read data strobe, one cycle after the read |
| pinPending | input | NUM_PINS | Per-pin request bits from the input stage |
| statValid | input | 1 | Status port load strobe |
| statPin | input | PIN_W | Entry whose status bits are loaded |
| statRemoteIrr | input | 1 | New remote IRR value |
| statDelivery | input | 1 | New delivery-status value |
| maskChgValid | output | 1 | Mask-change notification |
| maskChgPin | output | PIN_W | Pin whose mask changed |
| maskChgValue | output | 1 | New mask value |
| svcReqValid | output | 1 | Service request strobe |
| svcReqPin | output | PIN_W | Pin to be serviced |

## Verification
Every result the block produces comes from a register loaded at the edge that accepts the access. Read data, the mask-change pulse, the service request and the updated register contents are therefore all due exactly one cycle after that edge. The bench changes inputs on the falling edge, waits for one rising edge, and samples at the next falling edge. A pulse or read value is caught in the only cycle it is allowed to exist, and its absence is checked in that same cycle. The contents of the register file are always checked through later window reads, never through internal signals.

// File: rtl/irq_window_pkg.sv
package irq_window_pkg;

  // Redirection entry bit positions
  localparam int F_DSTAT = 12;
  localparam int F_RIRR  = 14;
  localparam int F_TRIG  = 15;
  localparam int F_MASK  = 16;

  // Index values below the table base
  localparam logic [7:0] IDX_ID    = 8'h00;
  localparam logic [7:0] IDX_VER   = 8'h01;
  localparam logic [7:0] IDX_ARB   = 8'h02;
  localparam logic [7:0] IDX_TABLE = 8'h10;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_SEL,
    SRC_VER,
    SRC_ID,
    SRC_ENTRY,
    SRC_ONES
  } rdSrc_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic       rdEn;
    rdSrc_e     rdSrc;
    logic       idWr;
    logic       entryWr;
    logic       hiHalf;
    logic [6:0] entryIdx;
  } winCmd_t;

endpackage

// File: rtl/irq_window_ctrl.sv
module irq_window_ctrl
  import irq_window_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] SEL_OFF  = 8'h00,
  parameter logic [7:0] WIN_OFF  = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [7:0]        selValue,
  output winCmd_t           cmd
);

  logic [7:0] selReg;
  logic       isSelOff;
  logic       isWinOff;
  logic [7:0] entryNum;
  logic       inTable;

  assign isSelOff = (busAddr[7:0] == SEL_OFF);
  assign isWinOff = (busAddr[7:0] == WIN_OFF);
  assign entryNum = (selReg - IDX_TABLE) >> 1;
  assign inTable  = (selReg >= IDX_TABLE) && (entryNum < 8'(NUM_PINS));
  assign selValue = selReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
    end else if (busSel && busWrite && isSelOff) begin
      selReg <= busWdata[7:0];
    end
  end

  always_comb begin
    cmd          = '0;
    cmd.rdSrc    = SRC_ZERO;
    cmd.rdEn     = busSel && !busWrite;
    cmd.hiHalf   = selReg[0];
    cmd.entryIdx = entryNum[6:0];
    if (busSel) begin
      if (isSelOff) begin
        cmd.rdSrc = SRC_SEL;
      end else if (isWinOff) begin
        unique case (selReg)
          IDX_ID: begin
            cmd.rdSrc = SRC_ID;
            cmd.idWr  = busWrite;
          end
          IDX_VER: cmd.rdSrc = SRC_VER;
          IDX_ARB: cmd.rdSrc = SRC_ID;
          default: begin
            if (inTable) begin
              cmd.rdSrc   = SRC_ENTRY;
              cmd.entryWr = busWrite;
            end else begin
              cmd.rdSrc = SRC_ONES;
            end
          end
        endcase
      end
    end
  end

  // R1: the select register keeps exactly the low byte of a select write
  p_sel_store_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && isSelOff) |=> (selReg == $past(busWdata[7:0])));

  // R2: accesses off the two decoded offsets raise no strobe
  p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !isSelOff && !isWinOff) |-> (!cmd.entryWr && !cmd.idWr));

endmodule

// File: rtl/irq_window_regs.sv
module irq_window_regs
  import irq_window_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11,
  parameter int         PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  winCmd_t             cmd,
  input  logic [7:0]          selValue,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                busRdValid,
  input  logic [NUM_PINS-1:0] pinPending,
  input  logic                statValid,
  input  logic [PIN_W-1:0]    statPin,
  input  logic                statRemoteIrr,
  input  logic                statDelivery,
  output logic                maskChgValid,
  output logic [PIN_W-1:0]    maskChgPin,
  output logic                maskChgValue,
  output logic                svcReqValid,
  output logic [PIN_W-1:0]    svcReqPin
);

  localparam logic [63:0] RST_ENTRY = 64'(1) << F_MASK;
  localparam logic [31:0] VER_WORD  = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

  logic [NUM_PINS-1:0][63:0] tblFlat;
  logic [63:0]               curEntry;
  logic [63:0]               mergedEntry;
  logic                      curPending;
  logic [3:0]                idReg;

  // Select the addressed entry without indexing past the table
  always_comb begin
    curEntry   = '0;
    curPending = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (cmd.entryIdx == 7'(i)) begin
        curEntry   = tblFlat[i];
        curPending = pinPending[i];
      end
    end
  end

  // Merge the written half, restore the status bits, clear remote IRR on edge
  always_comb begin
    mergedEntry = cmd.hiHalf ? {busWdata, curEntry[31:0]}
                             : {curEntry[63:32], busWdata};
    mergedEntry[F_DSTAT] = curEntry[F_DSTAT];
    mergedEntry[F_RIRR]  = curEntry[F_RIRR] && mergedEntry[F_TRIG];
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gEntry
    logic [63:0] entryQ;
    logic [63:0] entryD;
    logic        wrThis;
    logic        statThis;

    assign wrThis   = cmd.entryWr && (cmd.entryIdx == 7'(g));
    assign statThis = statValid && (statPin == PIN_W'(g));

    always_comb begin
      entryD = entryQ;
      if (wrThis) begin
        entryD = mergedEntry;
      end
      if (statThis) begin
        entryD[F_RIRR]  = statRemoteIrr;
        entryD[F_DSTAT] = statDelivery;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryQ <= RST_ENTRY;
      end else begin
        entryQ <= entryD;
      end
    end

    assign tblFlat[g] = entryQ;

    // R7: a bus write never changes delivery status
    p_dstat_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
      (wrThis && !statThis) |=> $stable(entryQ[F_DSTAT]));

    // R7: a bus write never raises remote IRR
    p_rirr_norise_r7: assert property (@(posedge clk) disable iff (!rstN)
      (wrThis && !statThis) |=> !$rose(entryQ[F_RIRR]));

    // R8: an edge-mode entry has remote IRR clear after a bus write
    p_edge_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      (wrThis && !statThis) |=> (entryQ[F_TRIG] || !entryQ[F_RIRR]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg <= '0;
    end else if (cmd.idWr) begin
      idReg <= busWdata[27:24];
    end
  end

  // Notifications for the interrupt delivery side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskChgValid <= 1'b0;
      maskChgPin   <= '0;
      maskChgValue <= 1'b0;
      svcReqValid  <= 1'b0;
      svcReqPin    <= '0;
    end else begin
      maskChgValid <= cmd.entryWr && (mergedEntry[F_MASK] != curEntry[F_MASK]);
      maskChgPin   <= PIN_W'(cmd.entryIdx);
      maskChgValue <= mergedEntry[F_MASK];
      svcReqValid  <= cmd.entryWr && mergedEntry[F_TRIG] && curPending;
      svcReqPin    <= PIN_W'(cmd.entryIdx);
    end
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdValid <= 1'b0;
      busRdata   <= '0;
    end else begin
      busRdValid <= cmd.rdEn;
      if (cmd.rdEn) begin
        unique case (cmd.rdSrc)
          SRC_SEL:   busRdata <= {24'h0, selValue};
          SRC_VER:   busRdata <= VER_WORD;
          SRC_ID:    busRdata <= {4'h0, idReg, 24'h0};
          SRC_ENTRY: busRdata <= cmd.hiHalf ? curEntry[63:32] : curEntry[31:0];
          SRC_ONES:  busRdata <= '1;
          default:   busRdata <= '0;
        endcase
      end
    end
  end

  logic [NUM_PINS-1:0] maskVec;
  logic [NUM_PINS-1:0] levelVec;
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      maskVec[i]  = tblFlat[i][F_MASK];
      levelVec[i] = tblFlat[i][F_TRIG];
    end
  end

  // R9: the notified mask value matches the stored entry
  p_mask_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    maskChgValid |-> (maskChgValue == maskVec[maskChgPin]));

  // R10: a service request only names a level-mode entry
  p_svc_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    svcReqValid |-> levelVec[svcReqPin]);

  // R12: every accepted read returns data in the next cycle
  p_rd_latency_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rdEn |=> busRdValid);

endmodule

// File: rtl/irq_window_top.sv
module irq_window_top
  import irq_window_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11,
  localparam int        PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [7:0]          busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                busRdValid,
  input  logic [NUM_PINS-1:0] pinPending,
  input  logic                statValid,
  input  logic [PIN_W-1:0]    statPin,
  input  logic                statRemoteIrr,
  input  logic                statDelivery,
  output logic                maskChgValid,
  output logic [PIN_W-1:0]    maskChgPin,
  output logic                maskChgValue,
  output logic                svcReqValid,
  output logic [PIN_W-1:0]    svcReqPin
);

  winCmd_t    cmd;
  logic [7:0] selValue;

  irq_window_ctrl #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (8)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .selValue (selValue),
    .cmd      (cmd)
  );

  irq_window_regs #(
    .NUM_PINS (NUM_PINS),
    .VERSION  (VERSION),
    .PIN_W    (PIN_W)
  ) uRegs (
    .clk           (clk),
    .rstN          (rstN),
    .cmd           (cmd),
    .selValue      (selValue),
    .busWdata      (busWdata),
    .busRdata      (busRdata),
    .busRdValid    (busRdValid),
    .pinPending    (pinPending),
    .statValid     (statValid),
    .statPin       (statPin),
    .statRemoteIrr (statRemoteIrr),
    .statDelivery  (statDelivery),
    .maskChgValid  (maskChgValid),
    .maskChgPin    (maskChgPin),
    .maskChgValue  (maskChgValue),
    .svcReqValid   (svcReqValid),
    .svcReqPin     (svcReqPin)
  );

endmodule

// File: tb/sim_irq_window_top.sv
module sim_irq_window_top;

  localparam int  NUM_PINS = 24;
  localparam int  PIN_W    = 5;
  localparam time CLK_T    = 8ns;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                busSel = 1'b0;
  logic                busWrite = 1'b0;
  logic [7:0]          busAddr = '0;
  logic [31:0]         busWdata = '0;
  logic [31:0]         busRdata;
  logic                busRdValid;
  logic [NUM_PINS-1:0] pinPending = '0;
  logic                statValid = 1'b0;
  logic [PIN_W-1:0]    statPin = '0;
  logic                statRemoteIrr = 1'b0;
  logic                statDelivery = 1'b0;
  logic                maskChgValid;
  logic [PIN_W-1:0]    maskChgPin;
  logic                maskChgValue;
  logic                svcReqValid;
  logic [PIN_W-1:0]    svcReqPin;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic             gotMask;
  logic [PIN_W-1:0] gotMaskPin;
  logic             gotMaskVal;
  logic             gotSvc;
  logic [PIN_W-1:0] gotSvcPin;
  logic             gotRdValid;
  logic             preRdValid;

  always #(CLK_T/2) clk = ~clk;

  irq_window_top u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRdValid(busRdValid), .pinPending(pinPending), .statValid(statValid),
    .statPin(statPin), .statRemoteIrr(statRemoteIrr), .statDelivery(statDelivery),
    .maskChgValid(maskChgValid), .maskChgPin(maskChgPin), .maskChgValue(maskChgValue),
    .svcReqValid(svcReqValid), .svcReqPin(svcReqPin)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; results sampled at the next falling edge
  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    gotMask = maskChgValid; gotMaskPin = maskChgPin; gotMaskVal = maskChgValue;
    gotSvc = svcReqValid; gotSvcPin = svcReqPin;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    preRdValid = busRdValid;
    @(posedge clk); @(negedge clk);
    d = busRdata; gotRdValid = busRdValid;
    busSel = 1'b0;
  endtask

  task automatic winRd(input logic [7:0] s, output logic [31:0] d);
    busWr(8'h00, {24'h0, s});
    busRd(8'h10, d);
  endtask

  task automatic winWr(input logic [7:0] s, input logic [31:0] d);
    busWr(8'h00, {24'h0, s});
    busWr(8'h10, d);
  endtask

  task automatic setStat(input int pin, input logic rirr, input logic ds);
    statValid = 1'b1; statPin = PIN_W'(pin); statRemoteIrr = rirr; statDelivery = ds;
    @(posedge clk); @(negedge clk);
    statValid = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRd(8'h00, d);   chk("R11 select after reset", d, 32'h0);
    chk("R12 no valid before read", {31'h0, preRdValid}, 32'h0);
    chk("R12 valid after read", {31'h0, gotRdValid}, 32'h1);
    winRd(8'h00, d);   chk("R11 id after reset", d, 32'h0);
    winRd(8'h10, d);   chk("R11 entry0 low after reset", d, 32'h00010000);
    winRd(8'h3E, d);   chk("R11 entry23 low after reset", d, 32'h00010000);
    winRd(8'h3F, d);   chk("R11 entry23 high after reset", d, 32'h0);
  endtask

  task automatic testSelectAndOffsets();
    logic [31:0] d;
    busWr(8'h00, 32'h0000_1234);
    busRd(8'h00, d);   chk("R1 select keeps low byte", d, 32'h34);
    busWr(8'h20, 32'hFFFF_FFFF);
    busRd(8'h20, d);   chk("R2 other offset reads zero", d, 32'h0);
    busRd(8'h00, d);   chk("R2 other offset write ignored", d, 32'h34);
    busRd(8'h04, d);   chk("R2 unaligned offset reads zero", d, 32'h0);
  endtask

  task automatic testVersionId();
    logic [31:0] d;
    winRd(8'h01, d);   chk("R3 version word", d, 32'h00170011);
    winWr(8'h01, 32'hFFFF_FFFF);
    busRd(8'h10, d);   chk("R3 version write ignored", d, 32'h00170011);
    winWr(8'h00, 32'hA5FF_FFFF);
    busRd(8'h10, d);   chk("R4 id stores bits 27:24", d, 32'h05000000);
    winRd(8'h02, d);   chk("R4 arbitration index reads id", d, 32'h05000000);
    winWr(8'h02, 32'h0F00_0000);
    winRd(8'h00, d);   chk("R4 arbitration write ignored", d, 32'h05000000);
  endtask

  task automatic testMapping();
    logic [31:0] d;
    winWr(8'h1A, 32'h0000_00AB);
    winWr(8'h1B, 32'hC300_0000);
    winRd(8'h1A, d);   chk("R5 entry5 low half", d, 32'h000000AB);
    winRd(8'h1B, d);   chk("R5 entry5 high half", d, 32'hC3000000);
    winRd(8'h18, d);   chk("R5 neighbour entry4 untouched", d, 32'h00010000);
    winRd(8'h1C, d);   chk("R5 neighbour entry6 untouched", d, 32'h00010000);
  endtask

  task automatic testOutOfRange();
    logic [31:0] d;
    winRd(8'h40, d);   chk("R6 entry24 reads ones", d, 32'hFFFFFFFF);
    winRd(8'hFF, d);   chk("R6 top select reads ones", d, 32'hFFFFFFFF);
    winRd(8'h05, d);   chk("R6 gap select reads ones", d, 32'hFFFFFFFF);
    winWr(8'h40, 32'h0);
    winRd(8'h3E, d);   chk("R6 discarded write leaves entry23", d, 32'h00010000);
  endtask

  task automatic testStatusKeep();
    logic [31:0] d;
    winWr(8'h1E, 32'h0000_A020);
    setStat(7, 1'b1, 1'b1);
    winRd(8'h1E, d);   chk("R7 status port loads bits", d, 32'h0000F020);
    winWr(8'h1E, 32'h0000_8020);
    busRd(8'h10, d);   chk("R7 write keeps set status bits", d, 32'h0000D020);
    winWr(8'h22, 32'h0000_D021);
    busRd(8'h10, d);   chk("R7 write cannot set status bits", d, 32'h00008021);
    winWr(8'h1E, 32'h0000_0020);
    busRd(8'h10, d);   chk("R8 edge mode clears remote IRR", d, 32'h00001020);
    winWr(8'h1E, 32'h0000_8020);
    setStat(7, 1'b1, 1'b0);
    winWr(8'h1F, 32'h0100_0000);
    winRd(8'h1E, d);   chk("R8 level entry keeps remote IRR", d, 32'h0000C020);
  endtask

  task automatic testMaskPulse();
    winWr(8'h16, 32'h0000_0030);
    chk("R9 unmask pulse", {31'h0, gotMask}, 32'h1);
    chk("R9 unmask pin", {27'h0, gotMaskPin}, 32'd3);
    chk("R9 unmask value", {31'h0, gotMaskVal}, 32'h0);
    busWr(8'h10, 32'h0000_0031);
    chk("R9 no pulse when mask kept", {31'h0, gotMask}, 32'h0);
    busWr(8'h10, 32'h0001_0031);
    chk("R9 mask pulse value", {31'h0, gotMaskVal}, 32'h1);
    chk("R9 mask pulse seen", {31'h0, gotMask}, 32'h1);
    winWr(8'h17, 32'hFFFF_FFFF);
    chk("R9 high half no pulse", {31'h0, gotMask}, 32'h0);
  endtask

  task automatic testService();
    pinPending = '0;
    pinPending[11] = 1'b1;
    winWr(8'h26, 32'h0001_8040);
    chk("R10 level pending service", {31'h0, gotSvc}, 32'h1);
    chk("R10 service pin", {27'h0, gotSvcPin}, 32'd11);
    winWr(8'h27, 32'h0200_0000);
    chk("R10 high half write services", {31'h0, gotSvc}, 32'h1);
    winWr(8'h26, 32'h0000_0040);
    chk("R10 edge write no service", {31'h0, gotSvc}, 32'h0);
    pinPending[11] = 1'b0;
    winWr(8'h26, 32'h0000_8040);
    chk("R10 level idle no service", {31'h0, gotSvc}, 32'h0);
    pinPending = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSelectAndOffsets();
    testVersionId();
    testMapping();
    testOutOfRange();
    testStatusKeep();
    testMaskPulse();
    testService();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_T * 100000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule